// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a small in-order integer core that executes a nine-instruction, fixed-width 32-bit subset: five register-to-register ALU operations, a word load, a word store, an equality branch and an absolute jump. Work moves through five stages: fetch, decode with register read, execute, data memory, and register write-back. Each stage boundary is a pipeline register. One instruction is fetched per cycle. The instruction and data memories are word arrays inside the block. A load port fills them while the core is held in reset.

Hazards are resolved in hardware. Results still in flight reach the ALU through forwarding paths. A write-back in the same cycle as a read reaches the register read through a bypass. A load followed at once by a consumer costs one frozen cycle and one bubble. A taken branch squashes the two younger instructions, and a jump squashes the one instruction behind it. The core is observed through three ports: the fetch address, the register write-back, and the data-memory store.

Top module: `pipe5_core`

## Requirements
- R1: Fields are op = bits 31:26, rs = 25:21, rt = 20:16, rd = 15:11, funct = 5:0, imm = 15:0. Op 0x00 is register-register with funct 0x20 add, 0x22 sub, 0x24 and, 0x25 or, 0x2A set-less-than (signed, result 1 or 0), and writes rd. Op 0x23 loads a word into rt. Op 0x2B stores rt. Op 0x04 is branch-if-equal. Op 0x02 is jump. Any other word, including all zeros, is a no-op.
- R2: After reset the first fetch is at address 0, and the fetch address rises by 4 every cycle when no hazard is present. Suppose an instruction is fetched between clock edges k and k+1 and sees no stall. Its write-back then shows on `wb_en`/`wb_reg`/`wb_data` after edge k+4.
- R3: An ALU operand whose source register was written by either of the two preceding instructions receives the new value. When both of them wrote that register, the younger one's value is used.
- R4: A register read in decode returns the value being written back in the same cycle.
- R5: Suppose an instruction uses (rs or rt) the non-zero destination of the load directly ahead of it. Exactly one bubble is inserted, and its write-back arrives one cycle later than R2 gives.
- R6: During a load-use stall the fetch address and the fetched instruction are held for one cycle.
- R7: A branch-if-equal is resolved in execute. When taken, the next fetch is at (branch address + 4) + sign-extended imm × 4, and the two younger instructions are discarded. A taken branch overrides a jump in decode at the same time.
- R8: A jump redirects from decode to {bits 31:28 of (jump address + 4), imm26, 00} and discards the single instruction fetched behind it.
- R9: While `rst_n` is low at a clock edge, the pipeline holds only no-ops, the fetch address becomes 0, and all registers clear. `wb_en` and `st_en` stay low.
- R10: Register 0 always reads as 0. A write to it produces no write-back and has no effect.
- R11: The load and store address is rs + sign-extended imm, used as a byte address of a word. A store shows on `st_en`/`st_addr`/`st_data` one cycle before the slot where it would write back. A later load returns the stored word. With `prog_we` high, `prog_dsel` = 0 writes instruction word `prog_addr` and 1 writes data word `prog_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_we | input | 1 | Memory load strobe |
| prog_dsel | input | 1 | Load target: 0 instruction memory, 1 data memory |
| prog_addr | input | AW | Word index for the load |
| prog_data | input | 32 | Word to load |
| fetch_pc | output | 32 | Address being fetched this cycle |
| wb_en | output | 1 | Register write-back this cycle |
| wb_reg | output | 5 | Destination register of the write-back |
| wb_data | output | 32 | Value written back |
| st_en | output | 1 | Data-memory store this cycle |
| st_addr | output | 32 | Byte address of the store |
| st_data | output | 32 | Stored word |

## Verification
The bench counts clock edges from the release of reset. Each write-back is due four edges after its fetch edge, one edge later for each load-use bubble, and a taken branch or jump shifts every later instruction by its redirect delay. A monitor samples the write-back and store ports on the falling edge and records the edge count along with the register and value. Each directed program then compares that log with a list of expected events written from those timing rules, so a result that is correct but early or late still fails. Fetch addresses are checked at the exact edges where a stall holds them or a redirect changes them.

// File: rtl/pipe5_pkg.sv
// Shared encodings and control bundle for the five-stage core.
// Assumes 32-bit instruction words with the field layout given in the brief.
package pipe5_pkg;

    localparam logic [5:0] OPC_REG    = 6'h00;
    localparam logic [5:0] OPC_LOAD   = 6'h23;
    localparam logic [5:0] OPC_STORE  = 6'h2B;
    localparam logic [5:0] OPC_BEQ    = 6'h04;
    localparam logic [5:0] OPC_JUMP   = 6'h02;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
    } alu_op_e;

    typedef enum logic [1:0] {
        FWD_REG, FWD_MEM, FWD_WB
    } fwd_sel_e;

    typedef struct packed {
        logic    reg_wr;
        logic    mem_rd;
        logic    mem_wr;
        logic    branch;
        logic    use_imm;
        alu_op_e alu_op;
    } ctrl_t;

    localparam ctrl_t CTRL_NOP = '{reg_wr: 1'b0, mem_rd: 1'b0, mem_wr: 1'b0,
                                   branch: 1'b0, use_imm: 1'b0, alu_op: ALU_ADD};

endpackage

// File: rtl/pipe5_decode.sv
// Instruction decoder: turns one instruction word into the control bundle,
// the destination register and a jump flag. Unknown words decode to no-ops.
// Assumes the register-0 write suppression lives here (reg_wr cleared).
module pipe5_decode
    import pipe5_pkg::*;
(
    input  logic [31:0] instr,
    output ctrl_t       ctrl,
    output logic        is_jump,
    output logic [4:0]  dest
);
    logic [5:0] opc;
    logic [5:0] fn;
    logic       unused_fields;

    assign opc = instr[31:26];
    assign fn  = instr[5:0];
    assign unused_fields = ^{instr[25:21], instr[10:6]};

    // Purpose: map opcode and function code onto the control bundle.
    always_comb begin
        ctrl    = CTRL_NOP;
        is_jump = 1'b0;
        dest    = 5'd0;
        case (opc)
            OPC_REG: begin
                dest        = instr[15:11];
                ctrl.reg_wr = 1'b1;
                case (fn)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    default: ctrl.reg_wr = 1'b0;
                endcase
            end
            OPC_LOAD: begin
                dest         = instr[20:16];
                ctrl.reg_wr  = 1'b1;
                ctrl.mem_rd  = 1'b1;
                ctrl.use_imm = 1'b1;
            end
            OPC_STORE: begin
                ctrl.mem_wr  = 1'b1;
                ctrl.use_imm = 1'b1;
            end
            OPC_BEQ:  ctrl.branch = 1'b1;
            OPC_JUMP: is_jump     = 1'b1;
            default:  ;
        endcase
        if (dest == 5'd0) begin
            ctrl.reg_wr = 1'b0;
        end
    end
endmodule

// File: rtl/pipe5_alu.sv
// Execute-stage ALU: add, subtract, and, or, signed set-less-than.
// Assumes operands arrive already forwarded.
module pipe5_alu
    import pipe5_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y
);
    // Purpose: select the arithmetic or logic result for the opcode.
    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/pipe5_regfile.sv
// Register file: two read ports, one write port, register 0 fixed at zero.
// A read of the register being written this cycle returns the new value,
// so decode sees write-back without an extra stall.
module pipe5_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int RA  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RA-1:0]   rs_a,
    input  logic [RA-1:0]   rs_b,
    output logic [XLEN-1:0] rd_a,
    output logic [XLEN-1:0] rd_b,
    input  logic            wr_en,
    input  logic [RA-1:0]   wr_addr,
    input  logic [XLEN-1:0] wr_data
);
    logic [XLEN-1:0] regs [NREG];
    logic [RA-1:0]   rsel [2];
    logic [XLEN-1:0] rval [2];

    assign rsel[0] = rs_a;
    assign rsel[1] = rs_b;
    assign rd_a    = rval[0];
    assign rd_b    = rval[1];

    // Purpose: clear all registers on reset, else accept one write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (wr_en && wr_addr != '0) begin
            regs[wr_addr] <= wr_data;
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_rport
        // Purpose: read port with zero register and write-back bypass.
        always_comb begin
            if (rsel[p] == '0)                        rval[p] = '0;
            else if (wr_en && wr_addr == rsel[p])     rval[p] = wr_data;
            else                                      rval[p] = regs[rsel[p]];
        end
    end

    a_r10_zero_reg_kept: assert property (@(posedge clk) disable iff (!rst_n)
        regs[0] == '0);
endmodule

// File: rtl/pipe5_hazard.sv
// Hazard unit: load-use stall detection and ALU operand forward selection.
// Assumes a load's destination is its rt and bubbles carry cleared control.
module pipe5_hazard
    import pipe5_pkg::*;
(
    input  logic     [4:0] id_rs,
    input  logic     [4:0] id_rt,
    input  logic           ex_load,
    input  logic     [4:0] ex_dest,
    input  logic     [4:0] ex_rs,
    input  logic     [4:0] ex_rt,
    input  logic           mem_wr,
    input  logic     [4:0] mem_dest,
    input  logic           wb_wr,
    input  logic     [4:0] wb_dest,
    output logic           stall,
    output fwd_sel_e       fwd_a,
    output fwd_sel_e       fwd_b
);
    // Purpose: the younger producer (memory stage) wins over write-back.
    function automatic fwd_sel_e pick(input logic [4:0] src, input logic m_wr,
                                      input logic [4:0] m_dst, input logic w_wr,
                                      input logic [4:0] w_dst);
        if (src != 5'd0 && m_wr && m_dst == src)      return FWD_MEM;
        else if (src != 5'd0 && w_wr && w_dst == src) return FWD_WB;
        else                                          return FWD_REG;
    endfunction

    // Purpose: freeze decode while a load's result is not yet available.
    always_comb begin
        stall = ex_load && ex_dest != 5'd0 && (ex_dest == id_rs || ex_dest == id_rt);
        fwd_a = pick(ex_rs, mem_wr, mem_dest, wb_wr, wb_dest);
        fwd_b = pick(ex_rt, mem_wr, mem_dest, wb_wr, wb_dest);
    end
endmodule

// File: rtl/pipe5_core.sv
// Five-stage in-order core: fetch, decode/read, execute, memory, write-back.
// Holds its own instruction and data word memories, filled by the load port
// while reset is held. Assumes XLEN is 32 and memories are word addressed.
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int MEM_WORDS = 64,
    localparam int AW       = $clog2(MEM_WORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            prog_we,
    input  logic            prog_dsel,
    input  logic [AW-1:0]   prog_addr,
    input  logic [31:0]     prog_data,
    output logic [XLEN-1:0] fetch_pc,
    output logic            wb_en,
    output logic [4:0]      wb_reg,
    output logic [XLEN-1:0] wb_data,
    output logic            st_en,
    output logic [XLEN-1:0] st_addr,
    output logic [XLEN-1:0] st_data
);
    logic [31:0]     imem [MEM_WORDS];
    logic [XLEN-1:0] dmem [MEM_WORDS];

    // fetch
    logic [XLEN-1:0] pc, pc_next, pc_plus4;
    logic [31:0]     if_instr;
    // IF/ID
    logic [31:0]     ifid_instr;
    logic [XLEN-1:0] ifid_pc4;
    // decode
    ctrl_t           id_ctrl;
    logic            id_jump;
    logic [4:0]      id_dest;
    logic [XLEN-1:0] id_rd_a, id_rd_b, id_imm, id_jtarget;
    // ID/EX
    ctrl_t           idex_ctrl;
    logic [XLEN-1:0] idex_a, idex_b, idex_imm, idex_pc4;
    logic [4:0]      idex_rs, idex_rt, idex_dest;
    // execute
    fwd_sel_e        fwd_a, fwd_b;
    logic            stall, ex_taken;
    logic [XLEN-1:0] ex_opa, ex_opb, ex_alu_b, ex_alu_y, ex_target;
    // EX/Mem
    logic            em_reg_wr, em_mem_rd, em_mem_wr;
    logic [XLEN-1:0] em_alu, em_sdata;
    logic [4:0]      em_dest;
    // Mem/WB
    logic            mw_reg_wr;
    logic [4:0]      mw_dest;
    logic [XLEN-1:0] mw_data;
    logic            unused_bits;

    assign unused_bits = ^{pc[1:0], pc[XLEN-1:AW+2], em_alu[1:0], em_alu[XLEN-1:AW+2]};

    // ---------------- fetch ----------------
    assign pc_plus4 = pc + XLEN'(4);
    assign if_instr = imem[pc[AW+1:2]];

    // Purpose: redirect priority is branch in execute, stall, jump, sequential.
    always_comb begin
        if (ex_taken)               pc_next = ex_target;
        else if (stall)             pc_next = pc;
        else if (id_jump)           pc_next = id_jtarget;
        else                        pc_next = pc_plus4;
    end

    // Purpose: program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= '0;
        else        pc <= pc_next;
    end

    // Purpose: instruction memory fill from the load port.
    always_ff @(posedge clk) begin
        if (prog_we && !prog_dsel) imem[prog_addr] <= prog_data;
    end

    // Purpose: IF/ID register with flush on redirect and hold on stall.
    always_ff @(posedge clk) begin
        if (!rst_n || ex_taken || (id_jump && !stall)) begin
            ifid_instr <= '0;
            ifid_pc4   <= '0;
        end else if (!stall) begin
            ifid_instr <= if_instr;
            ifid_pc4   <= pc_plus4;
        end
    end

    // ---------------- decode ----------------
    pipe5_decode u_decode (
        .instr   (ifid_instr),
        .ctrl    (id_ctrl),
        .is_jump (id_jump),
        .dest    (id_dest)
    );

    pipe5_regfile #(.XLEN(XLEN), .NREG(32)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .rs_a    (ifid_instr[25:21]),
        .rs_b    (ifid_instr[20:16]),
        .rd_a    (id_rd_a),
        .rd_b    (id_rd_b),
        .wr_en   (mw_reg_wr),
        .wr_addr (mw_dest),
        .wr_data (mw_data)
    );

    assign id_imm     = {{(XLEN-16){ifid_instr[15]}}, ifid_instr[15:0]};
    assign id_jtarget = {ifid_pc4[XLEN-1:XLEN-4], ifid_instr[25:0], 2'b00};

    pipe5_hazard u_hazard (
        .id_rs    (ifid_instr[25:21]),
        .id_rt    (ifid_instr[20:16]),
        .ex_load  (idex_ctrl.mem_rd),
        .ex_dest  (idex_dest),
        .ex_rs    (idex_rs),
        .ex_rt    (idex_rt),
        .mem_wr   (em_reg_wr),
        .mem_dest (em_dest),
        .wb_wr    (mw_reg_wr),
        .wb_dest  (mw_dest),
        .stall    (stall),
        .fwd_a    (fwd_a),
        .fwd_b    (fwd_b)
    );

    // Purpose: ID/EX register; a bubble or squash carries no-op control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idex_ctrl <= CTRL_NOP;
            idex_a    <= '0;
            idex_b    <= '0;
            idex_imm  <= '0;
            idex_pc4  <= '0;
            idex_rs   <= '0;
            idex_rt   <= '0;
            idex_dest <= '0;
        end else begin
            idex_ctrl <= (stall || ex_taken) ? CTRL_NOP : id_ctrl;
            idex_a    <= id_rd_a;
            idex_b    <= id_rd_b;
            idex_imm  <= id_imm;
            idex_pc4  <= ifid_pc4;
            idex_rs   <= ifid_instr[25:21];
            idex_rt   <= ifid_instr[20:16];
            idex_dest <= id_dest;
        end
    end

    // ---------------- execute ----------------
    // Purpose: operand forwarding muxes in front of the ALU.
    always_comb begin
        case (fwd_a)
            FWD_MEM: ex_opa = em_alu;
            FWD_WB:  ex_opa = mw_data;
            default: ex_opa = idex_a;
        endcase
        case (fwd_b)
            FWD_MEM: ex_opb = em_alu;
            FWD_WB:  ex_opb = mw_data;
            default: ex_opb = idex_b;
        endcase
    end

    assign ex_alu_b  = idex_ctrl.use_imm ? idex_imm : ex_opb;
    assign ex_taken  = idex_ctrl.branch && (ex_opa == ex_opb);
    assign ex_target = idex_pc4 + (idex_imm << 2);

    pipe5_alu #(.XLEN(XLEN)) u_alu (
        .a  (ex_opa),
        .b  (ex_alu_b),
        .op (idex_ctrl.alu_op),
        .y  (ex_alu_y)
    );

    // Purpose: EX/Mem register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            em_reg_wr <= 1'b0;
            em_mem_rd <= 1'b0;
            em_mem_wr <= 1'b0;
            em_alu    <= '0;
            em_sdata  <= '0;
            em_dest   <= '0;
        end else begin
            em_reg_wr <= idex_ctrl.reg_wr;
            em_mem_rd <= idex_ctrl.mem_rd;
            em_mem_wr <= idex_ctrl.mem_wr;
            em_alu    <= ex_alu_y;
            em_sdata  <= ex_opb;
            em_dest   <= idex_dest;
        end
    end

    // ---------------- memory ----------------
    // Purpose: data memory write from a store or the load port.
    always_ff @(posedge clk) begin
        if (prog_we && prog_dsel)  dmem[prog_addr]       <= prog_data;
        else if (rst_n && em_mem_wr) dmem[em_alu[AW+1:2]] <= em_sdata;
    end

    // Purpose: Mem/WB register, choosing load data or ALU result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mw_reg_wr <= 1'b0;
            mw_dest   <= '0;
            mw_data   <= '0;
        end else begin
            mw_reg_wr <= em_reg_wr;
            mw_dest   <= em_dest;
            mw_data   <= em_mem_rd ? dmem[em_alu[AW+1:2]] : em_alu;
        end
    end

    assign fetch_pc = pc;
    assign wb_en    = mw_reg_wr;
    assign wb_reg   = mw_dest;
    assign wb_data  = mw_data;
    assign st_en    = em_mem_wr;
    assign st_addr  = em_alu;
    assign st_data  = em_sdata;

    a_r2_pc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        pc[1:0] == 2'b00);
    a_r5_single_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);
    a_r6_stall_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (pc == $past(pc) && ifid_instr == $past(ifid_instr)));
    a_r7_branch_squash: assert property (@(posedge clk) disable iff (!rst_n)
        ex_taken |=> (ifid_instr == '0 && idex_ctrl == CTRL_NOP));
    a_r8_jump_squash: assert property (@(posedge clk) disable iff (!rst_n)
        (id_jump && !stall && !ex_taken) |=> (ifid_instr == '0));
endmodule

// File: tb/test_pipe5_core.sv
module test_pipe5_core;
    import pipe5_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_we = 1'b0;
    logic        prog_dsel = 1'b0;
    logic [5:0]  prog_addr = '0;
    logic [31:0] prog_data = '0;
    logic [31:0] fetch_pc, wb_data, st_addr, st_data;
    logic [4:0]  wb_reg;
    logic        wb_en, st_en;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int          ev_cyc [64];
    logic [4:0]  ev_reg [64];
    logic [31:0] ev_dat [64];
    int          ev_n = 0;
    int          sv_cyc [16];
    logic [31:0] sv_adr [16];
    logic [31:0] sv_dat [16];
    int          sv_n = 0;

    pipe5_core i_pipe5_core (
        .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_dsel(prog_dsel),
        .prog_addr(prog_addr), .prog_data(prog_data), .fetch_pc(fetch_pc),
        .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data),
        .st_en(st_en), .st_addr(st_addr), .st_data(st_data)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    // monitor: log write-backs and stores with the edge count
    always @(negedge clk) begin
        if (!rst_n) begin
            ev_n = 0;
            sv_n = 0;
        end else begin
            if (wb_en && ev_n < 64) begin
                ev_cyc[ev_n] = cyc; ev_reg[ev_n] = wb_reg; ev_dat[ev_n] = wb_data;
                ev_n++;
            end
            if (st_en && sv_n < 16) begin
                sv_cyc[sv_n] = cyc; sv_adr[sv_n] = st_addr; sv_dat[sv_n] = st_data;
                sv_n++;
            end
        end
    end

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rs, input int rt, input int rd);
        return {OPC_REG, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(input int tgt);
        return {OPC_JUMP, 26'(tgt)};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic put(input bit dsel, input int a, input logic [31:0] w);
        prog_we = 1'b1; prog_dsel = dsel; prog_addr = 6'(a); prog_data = w;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic begin_test();
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 64; i++) put(1'b0, i, 32'h0);
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic exp_wb(input int k, input int c, input int r, input logic [31:0] d, input string tag);
        if (k >= ev_n) begin
            chk(1'b0, tag, "missing write-back", 32'(ev_n), 32'(k + 1));
        end else begin
            chk(ev_cyc[k] == c && ev_reg[k] == 5'(r) && ev_dat[k] == d, tag,
                $sformatf("wb#%0d cyc=%0d reg=%0d", k, ev_cyc[k], ev_reg[k]), ev_dat[k], d);
            chk(ev_cyc[k] == c, tag, "wb cycle", 32'(ev_cyc[k]), 32'(c));
        end
    endtask

    task automatic exp_count(input int n, input string tag);
        chk(ev_n == n, tag, "write-back count", 32'(ev_n), 32'(n));
    endtask

    // R9: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(wb_en == 1'b0, "R9", "wb_en in reset", 32'(wb_en), 0);
        chk(st_en == 1'b0, "R9", "st_en in reset", 32'(st_en), 0);
        chk(fetch_pc == 0, "R9", "fetch_pc in reset", fetch_pc, 0);
    endtask

    // R1 R2 R3 R4 R10: ALU ops, forwarding, bypass, register 0
    task automatic t_alu_forward();
        begin_test();
        put(1'b1, 0, 32'd5);
        put(1'b1, 1, 32'd12);
        put(1'b0, 0,  enc_i(OPC_LOAD, 0, 1, 0));
        put(1'b0, 1,  enc_i(OPC_LOAD, 0, 2, 4));
        put(1'b0, 5,  enc_r(FN_ADD, 1, 2, 3));
        put(1'b0, 6,  enc_r(FN_SUB, 3, 1, 4));
        put(1'b0, 7,  enc_r(FN_OR,  4, 3, 5));
        put(1'b0, 8,  enc_r(FN_AND, 5, 3, 6));
        put(1'b0, 9,  enc_r(FN_SLT, 1, 2, 7));
        put(1'b0, 10, enc_r(FN_SLT, 2, 1, 8));
        put(1'b0, 11, enc_r(FN_SUB, 1, 2, 9));
        put(1'b0, 12, enc_r(FN_SLT, 9, 1, 10));
        put(1'b0, 13, enc_r(FN_ADD, 1, 2, 0));
        put(1'b0, 14, enc_r(FN_ADD, 0, 1, 11));
        put(1'b0, 15, enc_r(FN_ADD, 1, 1, 12));
        put(1'b0, 16, enc_r(FN_ADD, 2, 2, 12));
        put(1'b0, 17, enc_r(FN_ADD, 12, 0, 13));
        rst_n = 1'b1;
        wait_cyc(2);
        chk(fetch_pc == 32'd8, "R2", "sequential fetch", fetch_pc, 32'd8);
        wait_cyc(26);
        exp_wb(0, 4, 1, 32'd5, "R11");
        exp_wb(1, 5, 2, 32'd12, "R2");
        exp_wb(2, 9, 3, 32'd17, "R1");
        exp_wb(3, 10, 4, 32'd12, "R3");
        exp_wb(4, 11, 5, 32'd29, "R3");
        exp_wb(5, 12, 6, 32'd17, "R4");
        exp_wb(6, 13, 7, 32'd1, "R1");
        exp_wb(7, 14, 8, 32'd0, "R1");
        exp_wb(8, 15, 9, 32'hFFFF_FFF9, "R1");
        exp_wb(9, 16, 10, 32'd1, "R1");
        exp_wb(10, 18, 11, 32'd5, "R10");
        exp_wb(11, 19, 12, 32'd10, "R2");
        exp_wb(12, 20, 12, 32'd24, "R2");
        exp_wb(13, 21, 13, 32'd24, "R3");
        exp_count(14, "R10");
    endtask

    // R5 R6 R11: load-use bubble and store/load through memory
    task automatic t_load_use();
        begin_test();
        put(1'b1, 2, 32'd100);
        put(1'b0, 0, enc_i(OPC_LOAD, 0, 1, 8));
        put(1'b0, 1, enc_r(FN_ADD, 1, 1, 2));
        put(1'b0, 2, enc_i(OPC_STORE, 0, 2, 12));
        put(1'b0, 3, enc_i(OPC_LOAD, 0, 3, 12));
        rst_n = 1'b1;
        wait_cyc(2);
        chk(fetch_pc == 32'd8, "R6", "fetch before stall", fetch_pc, 32'd8);
        wait_cyc(3);
        chk(fetch_pc == 32'd8, "R6", "fetch held by stall", fetch_pc, 32'd8);
        wait_cyc(4);
        chk(fetch_pc == 32'd12, "R6", "fetch after stall", fetch_pc, 32'd12);
        wait_cyc(14);
        exp_wb(0, 4, 1, 32'd100, "R11");
        exp_wb(1, 6, 2, 32'd200, "R5");
        exp_wb(2, 8, 3, 32'd200, "R11");
        exp_count(3, "R5");
        chk(sv_n == 1, "R11", "store count", 32'(sv_n), 1);
        chk(sv_cyc[0] == 6 && sv_adr[0] == 32'd12 && sv_dat[0] == 32'd200, "R11",
            $sformatf("store cyc=%0d addr=%0d", sv_cyc[0], sv_adr[0]), sv_dat[0], 32'd200);
    endtask

    // R7: taken and not-taken branches, branch on forwarded operand
    task automatic t_branch();
        begin_test();
        put(1'b1, 0, 32'd5);
        put(1'b0, 0,  enc_i(OPC_LOAD, 0, 1, 0));
        put(1'b0, 1,  enc_i(OPC_LOAD, 0, 2, 0));
        put(1'b0, 4,  enc_i(OPC_BEQ, 1, 2, 3));
        put(1'b0, 5,  enc_r(FN_ADD, 1, 1, 3));
        put(1'b0, 6,  enc_r(FN_ADD, 1, 1, 4));
        put(1'b0, 7,  enc_r(FN_ADD, 1, 1, 5));
        put(1'b0, 8,  enc_r(FN_ADD, 1, 2, 6));
        put(1'b0, 9,  enc_i(OPC_BEQ, 1, 0, 5));
        put(1'b0, 10, enc_r(FN_ADD, 1, 1, 7));
        put(1'b0, 11, enc_r(FN_SUB, 1, 2, 8));
        put(1'b0, 12, enc_i(OPC_BEQ, 8, 0, 1));
        put(1'b0, 13, enc_r(FN_ADD, 1, 1, 9));
        put(1'b0, 14, enc_r(FN_ADD, 2, 2, 10));
        rst_n = 1'b1;
        wait_cyc(7);
        chk(fetch_pc == 32'd32, "R7", "branch target fetch", fetch_pc, 32'd32);
        wait_cyc(22);
        exp_wb(0, 4, 1, 32'd5, "R7");
        exp_wb(1, 5, 2, 32'd5, "R7");
        exp_wb(2, 11, 6, 32'd10, "R7");
        exp_wb(3, 13, 7, 32'd10, "R7");
        exp_wb(4, 14, 8, 32'd0, "R7");
        exp_wb(5, 18, 10, 32'd10, "R7");
        exp_count(6, "R7");
    endtask

    // R8: jump redirect, and a branch overriding a jump behind it (R7)
    task automatic t_jump();
        begin_test();
        put(1'b1, 0, 32'd5);
        put(1'b0, 0,  enc_i(OPC_LOAD, 0, 1, 0));
        put(1'b0, 3,  enc_j(6));
        put(1'b0, 4,  enc_r(FN_ADD, 1, 1, 2));
        put(1'b0, 5,  enc_r(FN_ADD, 1, 1, 3));
        put(1'b0, 6,  enc_r(FN_ADD, 1, 1, 4));
        put(1'b0, 7,  enc_i(OPC_LOAD, 0, 5, 0));
        put(1'b0, 9,  enc_i(OPC_BEQ, 0, 0, 2));
        put(1'b0, 10, enc_j(20));
        put(1'b0, 11, enc_r(FN_ADD, 1, 1, 8));
        put(1'b0, 12, enc_r(FN_ADD, 1, 1, 6));
        put(1'b0, 20, enc_r(FN_ADD, 1, 1, 7));
        rst_n = 1'b1;
        wait_cyc(5);
        chk(fetch_pc == 32'd24, "R8", "jump target fetch", fetch_pc, 32'd24);
        wait_cyc(20);
        exp_wb(0, 4, 1, 32'd5, "R8");
        exp_wb(1, 9, 4, 32'd10, "R8");
        exp_wb(2, 10, 5, 32'd5, "R8");
        exp_wb(3, 15, 6, 32'd10, "R7");
        exp_count(4, "R8");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_alu_forward();
        t_load_use();
        t_branch();
        t_jump();
        rst_n = 1'b0;
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule